// File: doc/BRIEF.md
# Byte-Addressed GPIO Port Controller

This block is a general-purpose I/O port that sits on a small register bus. The bus has one-cycle write and read strobes, an address, an 8-bit write data path and a registered 8-bit read data path. The port has as many pins as its register width, which is 8, 16, 32 or 64 bits. Each register is reached one byte lane at a time.

Software can load the output latch as a whole word through the data register. It can also turn individual latch bits on through a write-one-to-set register, or off through a write-one-to-clear register. A build-time parameter picks how the direction register is used: a 1 means output, a 1 means input, or there is no direction register at all. With no direction register the pins act as open-drain lines. A second parameter reverses the pin-to-bit mapping.

Reads of the data register return the pad levels after a two-flop synchronizer.

Top module: `gpio_mmio_ctrl`

## Requirements
- R1: While `rst` is high, the registers take their reset values. The latch is all zeros, except in the no-direction mode where it is all ones so that no pin is pulled low. The direction register makes every pin an input: all zeros in output-high mode and all ones in input-high mode. `rd_data` is 0.
- R2: The address is split into two fields. `addr[AW-1:AW-2]` picks the register: 0 data, 1 set, 2 clear, 3 direction. `addr[IDXW-1:0]` picks the byte lane, where lane b covers register bits 8b+7..8b; in an 8-bit build the lane field is ignored. A data write replaces only the addressed latch byte with `wdata`, on the clock edge where `wr_en` is high.
- R3: A set write forces to 1 every latch bit of the addressed lane whose `wdata` bit is 1. All other latch bits keep their value.
- R4: A clear write forces to 0 every latch bit of the addressed lane whose `wdata` bit is 1. All other latch bits keep their value.
- R5: A direction write loads the addressed byte of the direction register. In output-high mode (`DIR_MODE` = DIR_OUT_HIGH) a pin's output enable equals its direction bit. In input-high mode (DIR_IN_HIGH) the output enable is the inverse of its direction bit.
- R6: In no-direction mode (DIR_NONE), writes to the direction register have no effect and the register reads back as 0. Each pin's output enable is high exactly when its latch bit is 0, which makes the pin open-drain.
- R7: `pad_out[n]` and `pad_oe[n]` come from register bit n. When `REVERSE` is set they come from register bit WIDTH-1-n instead. The same mapping places `pad_in[n]` in the data register readback.
- R8: A data register read returns `pad_in` through a two-flop synchronizer, whatever the pin's direction. After a pad change, the first two reads still return the old level and the third read returns the new one, with reads on consecutive cycles.
- R9: A read of the set or clear register returns the addressed latch byte. A read of the direction register returns the addressed direction byte.
- R10: `rd_data` is updated only on the clock edge where `rd_en` is high. It holds its value at all other times, and writes never change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | One-cycle write strobe |
| rd_en | input | 1 | One-cycle read strobe |
| addr | input | IDXW+2 | Register select (top two bits) and byte lane |
| wdata | input | 8 | Write data byte |
| rd_data | output | 8 | Registered read data byte |
| pad_in | input | WIDTH | Pad input levels |
| pad_out | output | WIDTH | Pad output values |
| pad_oe | output | WIDTH | Pad output enables (1 = drive) |

## Verification
The bench builds three copies of the block on one shared bus, so every mode is covered by the same write sequence:
- a 16-bit copy in output-high mode with reversed numbering;
- a 16-bit copy in input-high mode with straight numbering;
- an 8-bit copy with no direction register, where the lane bit is ignored.

At these widths every byte value can be swept through the data, set, clear and direction registers on both lanes, and through the pad inputs. Every resulting pad and readback value is compared against a bit-level model. The two-cycle synchronizer latency is pinned by back-to-back reads after a pad change.

// File: rtl/gpio_mmio_pkg.sv
package gpio_mmio_pkg;

    typedef enum logic [1:0] {
        DIR_NONE     = 2'd0,
        DIR_OUT_HIGH = 2'd1,
        DIR_IN_HIGH  = 2'd2
    } dir_mode_e;

    typedef enum logic [1:0] {
        SEL_DATA = 2'd0,
        SEL_SET  = 2'd1,
        SEL_CLR  = 2'd2,
        SEL_DIR  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic     wr;
        logic     rd;
        reg_sel_e sel;
    } bus_cmd_t;

    function automatic int lane_bits(input int nbytes);
        return (nbytes > 1) ? $clog2(nbytes) : 1;
    endfunction

endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/gpio_pinmap.sv
module gpio_pinmap #(
    parameter int WIDTH   = 32,
    parameter bit REVERSE = 1'b0
) (
    input  logic [WIDTH-1:0] src,
    output logic [WIDTH-1:0] dst
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (REVERSE) begin : g_rev
            assign dst[i] = src[WIDTH-1-i];
        end else begin : g_str
            assign dst[i] = src[i];
        end
    end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_mmio_pkg::*;
#(
    parameter int        WIDTH    = 32,
    parameter dir_mode_e DIR_MODE = DIR_OUT_HIGH,
    localparam int       BYTES    = WIDTH / 8
) (
    input  logic             clk,
    input  logic             rst,
    input  bus_cmd_t         cmd,
    input  logic [BYTES-1:0] lane_hit,
    input  logic [7:0]       wdata,
    output logic [WIDTH-1:0] latch_q,
    output logic [WIDTH-1:0] dir_q
);
    localparam logic [WIDTH-1:0] LATCH_INIT = (DIR_MODE == DIR_NONE)    ? '1 : '0;
    localparam logic [WIDTH-1:0] DIR_INIT   = (DIR_MODE == DIR_IN_HIGH) ? '1 : '0;

    logic [WIDTH-1:0] byte_en;
    logic [WIDTH-1:0] wide;
    logic [WIDTH-1:0] hit_bits;
    logic [WIDTH-1:0] latch_d;
    logic [WIDTH-1:0] dir_d;

    for (genvar b = 0; b < BYTES; b++) begin : g_lane
        assign byte_en[b*8 +: 8] = {8{lane_hit[b]}};
        assign wide[b*8 +: 8]    = wdata;
    end

    assign hit_bits = wide & byte_en;

    always_comb begin
        latch_d = latch_q;
        unique case (cmd.sel)
            SEL_DATA: latch_d = (latch_q & ~byte_en) | hit_bits;
            SEL_SET:  latch_d = latch_q | hit_bits;
            SEL_CLR:  latch_d = latch_q & ~hit_bits;
            default:  latch_d = latch_q;
        endcase
    end

    if (DIR_MODE == DIR_NONE) begin : g_nodir
        assign dir_d = '0;
    end else begin : g_dir
        assign dir_d = (cmd.sel == SEL_DIR) ? ((dir_q & ~byte_en) | hit_bits) : dir_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= LATCH_INIT;
            dir_q   <= DIR_INIT;
        end else if (cmd.wr) begin
            latch_q <= latch_d;
            dir_q   <= dir_d;
        end
    end
endmodule

// File: rtl/gpio_mmio_ctrl.sv
module gpio_mmio_ctrl
    import gpio_mmio_pkg::*;
#(
    parameter int        WIDTH    = 32,
    parameter dir_mode_e DIR_MODE = DIR_OUT_HIGH,
    parameter bit        REVERSE  = 1'b0,
    localparam int       BYTES    = WIDTH / 8,
    localparam int       IDXW     = lane_bits(BYTES),
    localparam int       AW       = IDXW + 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [AW-1:0]    addr,
    input  logic [7:0]       wdata,
    output logic [7:0]       rd_data,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_oe
);
    bus_cmd_t         cmd;
    logic [IDXW-1:0]  lane_i;
    logic [BYTES-1:0] lane_hit;
    logic [WIDTH-1:0] latch_q;
    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] oe_reg;
    logic [WIDTH-1:0] pad_sync;
    logic [WIDTH-1:0] pin_word;
    logic [WIDTH-1:0] rd_word;
    logic [7:0]       rd_byte;

    assign cmd.wr  = wr_en;
    assign cmd.rd  = rd_en;
    assign cmd.sel = reg_sel_e'(addr[AW-1 -: 2]);
    assign lane_i  = (BYTES == 1) ? '0 : addr[IDXW-1:0];

    for (genvar b = 0; b < BYTES; b++) begin : g_hit
        assign lane_hit[b] = (BYTES == 1) || (int'(addr[IDXW-1:0]) == b);
    end

    gpio_regs #(.WIDTH(WIDTH), .DIR_MODE(DIR_MODE)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .lane_hit (lane_hit),
        .wdata    (wdata),
        .latch_q  (latch_q),
        .dir_q    (dir_q)
    );

    if (DIR_MODE == DIR_OUT_HIGH) begin : g_oe_out
        assign oe_reg = dir_q;
    end else if (DIR_MODE == DIR_IN_HIGH) begin : g_oe_in
        assign oe_reg = ~dir_q;
    end else begin : g_oe_od
        assign oe_reg = ~latch_q;
    end

    gpio_pinmap #(.WIDTH(WIDTH), .REVERSE(REVERSE)) u_map_out (
        .src (latch_q),
        .dst (pad_out)
    );

    gpio_pinmap #(.WIDTH(WIDTH), .REVERSE(REVERSE)) u_map_oe (
        .src (oe_reg),
        .dst (pad_oe)
    );

    gpio_sync2 #(.WIDTH(WIDTH)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (pad_sync)
    );

    gpio_pinmap #(.WIDTH(WIDTH), .REVERSE(REVERSE)) u_map_in (
        .src (pad_sync),
        .dst (pin_word)
    );

    always_comb begin
        unique case (cmd.sel)
            SEL_DATA:         rd_word = pin_word;
            SEL_SET, SEL_CLR: rd_word = latch_q;
            default:          rd_word = dir_q;
        endcase
    end

    assign rd_byte = 8'(rd_word >> {lane_i, 3'b000});

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (cmd.rd) begin
            rd_data <= rd_byte;
        end
    end
endmodule

// File: rtl/gpio_mmio_chk.sv
module gpio_mmio_chk
    import gpio_mmio_pkg::*;
#(
    parameter int        WIDTH    = 32,
    parameter dir_mode_e DIR_MODE = DIR_OUT_HIGH,
    parameter int        IDXW     = 2,
    localparam int       AW       = IDXW + 2
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic             rd_en,
    input logic [AW-1:0]    addr,
    input logic [7:0]       wdata,
    input logic [7:0]       rd_data,
    input logic [WIDTH-1:0] latch_q,
    input logic [WIDTH-1:0] dir_q
);
    logic lane0;
    assign lane0 = (addr[IDXW-1:0] == '0);

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));

    p_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(latch_q));

    p_load_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && lane0 && addr[AW-1 -: 2] == 2'd0) |=> latch_q[7:0] == $past(wdata));

    p_set_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && lane0 && addr[AW-1 -: 2] == 2'd1)
        |=> latch_q[7:0] == ($past(latch_q[7:0]) | $past(wdata)));

    p_clr_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && lane0 && addr[AW-1 -: 2] == 2'd2)
        |=> latch_q[7:0] == ($past(latch_q[7:0]) & ~$past(wdata)));

    if (DIR_MODE == DIR_NONE) begin : g_chk_nodir
        p_dirfix_r6: assert property (@(posedge clk) disable iff (rst)
            wr_en |=> dir_q == '0);
    end else begin : g_chk_dir
        p_dirload_r5: assert property (@(posedge clk) disable iff (rst)
            (wr_en && lane0 && addr[AW-1 -: 2] == 2'd3) |=> dir_q[7:0] == $past(wdata));
    end
endmodule

bind gpio_mmio_ctrl gpio_mmio_chk #(
    .WIDTH    (WIDTH),
    .DIR_MODE (DIR_MODE),
    .IDXW     (IDXW)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .addr    (addr),
    .wdata   (wdata),
    .rd_data (rd_data),
    .latch_q (latch_q),
    .dir_q   (dir_q)
);

// File: tb/sim_gpio_mmio_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_mmio_ctrl;
    import gpio_mmio_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [15:0] pin0 = '0, pin1 = '0;
    logic [7:0]  pin2 = '0;
    logic [7:0]  rd0, rd1, rd2;
    logic [15:0] po0, oe0, po1, oe1;
    logic [7:0]  po2, oe2;

    logic [15:0] m_lat0, m_dir0, m_lat1, m_dir1;
    logic [7:0]  m_lat2;
    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    gpio_mmio_ctrl #(.WIDTH(16), .DIR_MODE(DIR_OUT_HIGH), .REVERSE(1'b1)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
        .rd_data(rd0), .pad_in(pin0), .pad_out(po0), .pad_oe(oe0));
    gpio_mmio_ctrl #(.WIDTH(16), .DIR_MODE(DIR_IN_HIGH), .REVERSE(1'b0)) u1 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
        .rd_data(rd1), .pad_in(pin1), .pad_out(po1), .pad_oe(oe1));
    gpio_mmio_ctrl #(.WIDTH(8), .DIR_MODE(DIR_NONE), .REVERSE(1'b0)) u2 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
        .rd_data(rd2), .pad_in(pin2), .pad_out(po2), .pad_oe(oe2));

    function automatic logic [15:0] rev16(input logic [15:0] x);
        logic [15:0] r;
        for (int i = 0; i < 16; i++) r[i] = x[15-i];
        return r;
    endfunction

    function automatic logic [15:0] upd16(input logic [15:0] cur, input int sel,
                                          input int lane, input logic [7:0] v);
        logic [15:0] m, w;
        m = 16'h00FF << (lane * 8);
        w = {v, v} & m;
        case (sel)
            0: return (cur & ~m) | w;
            1: return cur | w;
            2: return cur & ~w;
            default: return cur;
        endcase
    endfunction

    function automatic logic [7:0] upd8(input logic [7:0] cur, input int sel, input logic [7:0] v);
        case (sel)
            0: return v;
            1: return cur | v;
            2: return cur & ~v;
            default: return cur;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input int sel, input int lane, input logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b1; addr = {2'(sel), 1'(lane)}; wdata = v;
        @(negedge clk);
        wr_en = 1'b0;
        m_lat0 = upd16(m_lat0, sel, lane, v);
        m_lat1 = upd16(m_lat1, sel, lane, v);
        m_lat2 = upd8(m_lat2, sel, v);
        if (sel == 3) begin
            m_dir0 = upd16(m_dir0, 0, lane, v);
            m_dir1 = upd16(m_dir1, 0, lane, v);
        end
    endtask

    task automatic check_pads(input string req);
        chk(po0 === rev16(m_lat0), {req, " R7 u0 out"}, po0, rev16(m_lat0));
        chk(oe0 === rev16(m_dir0), {"R5 R7 u0 oe ", req}, oe0, rev16(m_dir0));
        chk(po1 === m_lat1, {req, " u1 out"}, po1, m_lat1);
        chk(oe1 === ~m_dir1, {"R5 u1 oe ", req}, oe1, ~m_dir1);
        chk(po2 === m_lat2, {req, " u2 out"}, {8'h0, po2}, {8'h0, m_lat2});
        chk(oe2 === ~m_lat2, {"R6 u2 oe ", req}, {8'h0, oe2}, {8'h0, ~m_lat2});
    endtask

    task automatic bus_read(input int sel, input int lane);
        @(negedge clk);
        rd_en = 1'b1; addr = {2'(sel), 1'(lane)};
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic check_read(input int sel, input int lane, input string req);
        logic [15:0] w0, w1;
        logic [7:0]  w2, e0, e1;
        bus_read(sel, lane);
        case (sel)
            0: begin w0 = rev16(pin0); w1 = pin1; w2 = pin2; end
            3: begin w0 = m_dir0; w1 = m_dir1; w2 = 8'h00; end
            default: begin w0 = m_lat0; w1 = m_lat1; w2 = m_lat2; end
        endcase
        e0 = 8'(w0 >> (lane * 8));
        e1 = 8'(w1 >> (lane * 8));
        chk(rd0 === e0, {req, " u0 read"}, {8'h0, rd0}, {8'h0, e0});
        chk(rd1 === e1, {req, " u1 read"}, {8'h0, rd1}, {8'h0, e1});
        chk(rd2 === w2, {req, " u2 read"}, {8'h0, rd2}, {8'h0, w2});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] hold;
        m_lat0 = '0; m_dir0 = '0; m_lat1 = '0; m_dir1 = '1; m_lat2 = 8'hFF;
        repeat (3) @(negedge clk);
        // R1 reset values
        check_pads("R1");
        chk(rd0 === 8'h00, "R1 rd_data", {8'h0, rd0}, 16'h0);
        rst = 1'b0;
        check_read(3, 0, "R1 R9 dir");
        check_read(3, 1, "R1 R9 dir");
        check_read(1, 1, "R1 R9 latch");

        // R2 data writes on every byte value and lane
        for (int lane = 0; lane < 2; lane++)
            for (int v = 0; v < 256; v++) begin
                bus_write(0, lane, 8'(v));
                check_pads("R2");
            end

        // R3 / R4 set and clear sweeps with readback (R9)
        for (int lane = 0; lane < 2; lane++)
            for (int v = 0; v < 256; v++) begin
                bus_write(1, lane, 8'(v));
                check_pads("R3");
                if (v % 17 == 0) check_read(1, lane, "R3 R9");
                bus_write(2, lane, 8'(v) ^ 8'h3C);
                check_pads("R4");
                if (v % 17 == 0) check_read(2, lane, "R4 R9");
            end

        // R5 / R6 direction sweep
        for (int lane = 0; lane < 2; lane++)
            for (int v = 0; v < 256; v++) begin
                bus_write(3, lane, 8'(v));
                check_pads("R5 R6");
                if (v % 15 == 0) check_read(3, lane, "R5 R6 R9");
            end

        // R8 / R7 pad input sweep
        for (int v = 0; v < 256; v++) begin
            @(negedge clk);
            pin0 = {8'(v), 8'(v) ^ 8'h5A};
            pin1 = {8'(v) ^ 8'hC3, 8'(v)};
            pin2 = 8'(v);
            repeat (2) @(negedge clk);
            check_read(0, v % 2, "R8 R7");
        end

        // R8 synchronizer latency: two stale reads then the new level
        @(negedge clk);
        pin0 = 16'h0000; pin1 = 16'h0000; pin2 = 8'h00;
        repeat (3) @(negedge clk);
        pin2 = 8'hA6;
        rd_en = 1'b1; addr = 3'b000;
        @(negedge clk);
        chk(rd2 === 8'h00, "R8 first read stale", {8'h0, rd2}, 16'h0000);
        @(negedge clk);
        chk(rd2 === 8'h00, "R8 second read stale", {8'h0, rd2}, 16'h0000);
        @(negedge clk);
        chk(rd2 === 8'hA6, "R8 third read new", {8'h0, rd2}, 16'h00A6);
        rd_en = 1'b0;

        // R10 rd_data holds without rd_en, across pad changes and writes
        hold = rd2;
        pin2 = 8'h19;
        repeat (4) @(negedge clk);
        bus_write(0, 0, 8'h77);
        chk(rd2 === hold, "R10 hold", {8'h0, rd2}, {8'h0, hold});
        check_pads("R10");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule